// File: doc/BRIEF.md
# Laser Transmit Fault and Disable Controller

This block decides when an optical transmitter must be shut off, and it keeps a latched record of transmit faults. Three things can request shut-off: a transmit-disable pin, a software disable bit that acts exactly like the pin, and the fault latch itself. Four monitor flags, each gated by its own enable bit, feed the fault latch. While the latch is set, the block drives a command that forces the laser bias and modulation settings to zero. It also pulls an open-drain fault pin active. A level that another device drives onto that pin is taken as one more fault source.

Each disable request is stretched internally for a settling window so that the power loop can recover. While the stretched disable is active, the low-side alarm and warning latches cannot capture, and the power-low flag cannot set the fault latch. The fault latch clears only after disable has been requested for a full reset-timer interval. If an enabled fault condition is still present at that moment, the latch sets again at once. The settling window and the reset interval are both given as parameters in clock cycles.

The pin inputs are asynchronous and pass through two-flop synchronizers. The flags, enables, software bit and low-side alarm inputs are synchronous to the clock.

Top module: `tx_safety_ctrl`

## Requirements
- R1: `dis_o` is high in every cycle in which `sw_dis_i` is high or `fault_gate_o` is high. It also goes high two clock edges after `dis_pin_i` rises, and not earlier.
- R2: `mon_flag_i`/`mon_en_i` bit positions are: 0 power high, 1 bias at maximum, 2 bias alarm, 3 power low. One clock edge after any bit has both its flag and its enable high, `fault_gate_o` is 1. A flag whose enable is 0 has no effect.
- R3: `ext_dis_o` is high while a disable request (synchronized pin or software bit) is present. After the request goes away, it stays high for exactly SETTLE_CYC more clock edges.
- R4: While `ext_dis_o` is high, no bit of `low_lat_o` can become set. Outside that window, a high `low_alm_i` bit sets its latch on the next edge, and the latch holds until a `low_clr_i` pulse on the same bit clears it. A set request wins over a clear in the same cycle.
- R5: While `ext_dis_o` is high, the power-low flag (bit 3) cannot set the fault latch. On the first edge after `ext_dis_o` falls, the same flag, if still enabled, sets the latch.
- R6: While the fault latch is set, `fault_gate_o` (the force-bias-and-modulation-to-zero command) and `fault_pad_oe_o` are both high.
- R7: When `fault_pad_i` is driven high externally while the block is not driving it, the latch sets on the third clock edge. For two cycles after the block releases the pin, its own echo does not set the latch again.
- R8: A set fault latch clears on the CLR_CYC-th consecutive clock edge with a disable request present. A request held for CLR_CYC-1 edges leaves the latch set.
- R9: If an enabled fault condition is present on the clearing edge, the latch stays set.
- R10: An active-low `rst_n` clears the fault latch, the settle counter and the alarm latches at once. All outputs are 0 after reset when the inputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| dis_pin_i | input | 1 | Transmit-disable pin, asynchronous |
| sw_dis_i | input | 1 | Software disable bit, synchronous |
| fault_pad_i | input | 1 | Level sensed on the open-drain fault pin, asynchronous |
| mon_flag_i | input | 4 | Monitor flags (see R2 for bit order) |
| mon_en_i | input | 4 | Per-flag fault enables |
| low_alm_i | input | LOW_N | Low-side alarm and warning events |
| low_clr_i | input | LOW_N | Per-bit clear of the low-side latches |
| dis_o | output | 1 | Combined transmitter disable |
| fault_gate_o | output | 1 | Fault latch state; forces bias and modulation to zero |
| fault_pad_oe_o | output | 1 | Pull-down enable for the open-drain fault pin |
| ext_dis_o | output | 1 | Stretched disable (settling window active) |
| low_lat_o | output | LOW_N | Latched low-side alarms and warnings |

## Verification
The fault set term is swept over all 256 flag and enable combinations, once with the settling window closed and once with it open. A design that drops an enable gate, or that blocks the wrong flag during settling, fails those sweeps. The timer is probed one edge short of the reset interval and exactly at it, and again with a fault held present. An off-by-one counter, or a clear that ignores live faults, shows up here. The stretch and the alarm inhibit are observed edge by edge around the end of the settling window, and the fault pin is checked both for the external-set delay and for a false re-trigger from its own released echo.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int unsigned FLG_N        = 4;
  localparam int unsigned FLG_PWR_HI   = 0;
  localparam int unsigned FLG_BIAS_MAX = 1;
  localparam int unsigned FLG_BIAS_ALM = 2;
  localparam int unsigned FLG_PWR_LO   = 3;

  // Enable mask applied to the flag set: power-low is held off while settling.
  function automatic logic [FLG_N-1:0] settle_mask(input logic settling);
    logic [FLG_N-1:0] m;
    m             = '1;
    m[FLG_PWR_LO] = ~settling;
    return m;
  endfunction
endpackage

// File: rtl/tsc_sync.sv
module tsc_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/tsc_stretch.sv
module tsc_stretch #(
  parameter int unsigned HOLD = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic act
);
  localparam int unsigned CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          busy;

  assign busy = (cnt_q != '0);

  always_comb begin
    cnt_en = req | busy;
    cnt_d  = cnt_q;
    if (req)       cnt_d = CW'(HOLD);
    else if (busy) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign act = req | busy;
endmodule

// File: rtl/tsc_fault_core.sv
module tsc_fault_core
  import tsc_pkg::*;
#(
  parameter int unsigned CLR_CYC = 1300000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FLG_N-1:0] flag,
  input  logic [FLG_N-1:0] en,
  input  logic             settling,
  input  logic             pad_s,
  input  logic             dis_req,
  output logic             gate,
  output logic             pad_oe,
  output logic             pad_src
);
  localparam int unsigned TW = $clog2(CLR_CYC + 1);

  logic          gate_q, gate_d;
  logic [1:0]    echo_q, echo_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          set_term;
  logic          clr_hit;
  logic          tmr_run;

  // The block's own pull-down is still visible through the synchronizer
  // for two cycles after release; ignore the pin for that long.
  assign pad_src  = pad_s & ~gate_q & ~(|echo_q);
  assign set_term = (|(flag & en & settle_mask(settling))) | pad_src;
  assign clr_hit  = dis_req & gate_q & (tmr_q == TW'(CLR_CYC - 1));
  assign tmr_run  = dis_req & gate_q & ~clr_hit;

  always_comb begin
    gate_d = set_term | (gate_q & ~clr_hit);
    tmr_d  = tmr_run ? tmr_q + 1'b1 : '0;
    echo_d = {echo_q[0], gate_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      tmr_q  <= '0;
      echo_q <= '0;
    end else begin
      gate_q <= gate_d;
      tmr_q  <= tmr_d;
      echo_q <= echo_d;
    end
  end

  assign gate   = gate_q;
  assign pad_oe = gate_q;
endmodule

// File: rtl/tsc_low_latch.sv
module tsc_low_latch #(
  parameter int unsigned N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] alm,
  input  logic [N-1:0] clr,
  input  logic         settling,
  output logic [N-1:0] lat
);
  logic [N-1:0] lat_q, lat_d;

  always_comb begin
    lat_d = (lat_q & ~clr) | (alm & ~{N{settling}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= lat_d;
  end

  assign lat = lat_q;
endmodule

// File: rtl/tx_safety_ctrl.sv
module tx_safety_ctrl
  import tsc_pkg::*;
#(
  parameter int unsigned LOW_N      = 11,
  parameter int unsigned SETTLE_CYC = 1000000,
  parameter int unsigned CLR_CYC    = 1300000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dis_pin_i,
  input  logic             sw_dis_i,
  input  logic             fault_pad_i,
  input  logic [FLG_N-1:0] mon_flag_i,
  input  logic [FLG_N-1:0] mon_en_i,
  input  logic [LOW_N-1:0] low_alm_i,
  input  logic [LOW_N-1:0] low_clr_i,
  output logic             dis_o,
  output logic             fault_gate_o,
  output logic             fault_pad_oe_o,
  output logic             ext_dis_o,
  output logic [LOW_N-1:0] low_lat_o
);
  logic       rst_meta_q, rst_sn;
  logic [1:0] pins_s;
  logic       dis_req;
  logic       pad_src;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sn     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sn     <= rst_meta_q;
    end
  end

  tsc_sync #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_sn),
    .d     ({fault_pad_i, dis_pin_i}),
    .q     (pins_s)
  );

  assign dis_req = pins_s[0] | sw_dis_i;

  tsc_stretch #(.HOLD(SETTLE_CYC)) u_stretch (
    .clk   (clk),
    .rst_n (rst_sn),
    .req   (dis_req),
    .act   (ext_dis_o)
  );

  tsc_fault_core #(.CLR_CYC(CLR_CYC)) u_core (
    .clk      (clk),
    .rst_n    (rst_sn),
    .flag     (mon_flag_i),
    .en       (mon_en_i),
    .settling (ext_dis_o),
    .pad_s    (pins_s[1]),
    .dis_req  (dis_req),
    .gate     (fault_gate_o),
    .pad_oe   (fault_pad_oe_o),
    .pad_src  (pad_src)
  );

  tsc_low_latch #(.N(LOW_N)) u_low (
    .clk      (clk),
    .rst_n    (rst_sn),
    .alm      (low_alm_i),
    .clr      (low_clr_i),
    .settling (ext_dis_o),
    .lat      (low_lat_o)
  );

  assign dis_o = dis_req | fault_gate_o;
endmodule

// File: rtl/tsc_chk.sv
module tsc_chk #(
  parameter int unsigned LOW_N = 11
) (
  input logic             clk,
  input logic             rst_sn,
  input logic             sw_dis,
  input logic             dis_req,
  input logic [3:0]       flag,
  input logic [3:0]       en,
  input logic             pad_src,
  input logic             ext_dis,
  input logic             gate,
  input logic             pad_oe,
  input logic             dis,
  input logic [LOW_N-1:0] lat
);
  // R1
  sw_forces_dis_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    sw_dis |-> dis);

  // R2
  enabled_flag_sets_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (|(flag & en & 4'b0111)) |=> gate);

  // R3
  req_stretches_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    dis_req |=> ext_dis);

  // R4
  no_low_capture_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    ext_dis |=> ((lat & ~$past(lat)) == '0));

  // R5
  pwr_lo_blocked_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (ext_dis && !gate && !pad_src && ((flag & en & 4'b0111) == 4'b0000)) |=> !gate);

  // R6
  gate_drives_pin_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    gate |-> (pad_oe && dis));

  // R8
  clear_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(gate) |-> $past(dis_req));
endmodule

bind tx_safety_ctrl tsc_chk #(.LOW_N(LOW_N)) u_tsc_chk (
  .clk     (clk),
  .rst_sn  (rst_sn),
  .sw_dis  (sw_dis_i),
  .dis_req (dis_req),
  .flag    (mon_flag_i),
  .en      (mon_en_i),
  .pad_src (pad_src),
  .ext_dis (ext_dis_o),
  .gate    (fault_gate_o),
  .pad_oe  (fault_pad_oe_o),
  .dis     (dis_o),
  .lat     (low_lat_o)
);

// File: tb/test_tx_safety_ctrl.sv
module test_tx_safety_ctrl;
  localparam int unsigned LOW_N  = 11;
  localparam int unsigned SET_C  = 6;
  localparam int unsigned CLR_C  = 10;

  logic             clk;
  logic             rst_n;
  logic             dis_pin;
  logic             sw_dis;
  logic             ext_drv;
  logic [3:0]       flag;
  logic [3:0]       en;
  logic [LOW_N-1:0] alm;
  logic [LOW_N-1:0] clr;
  logic             dis_o, gate_o, oe_o, ext_o;
  logic [LOW_N-1:0] lat_o;
  logic             pad;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  assign pad = oe_o | ext_drv;

  tx_safety_ctrl #(.LOW_N(LOW_N), .SETTLE_CYC(SET_C), .CLR_CYC(CLR_C)) i_tx_safety_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .dis_pin_i      (dis_pin),
    .sw_dis_i       (sw_dis),
    .fault_pad_i    (pad),
    .mon_flag_i     (flag),
    .mon_en_i       (en),
    .low_alm_i      (alm),
    .low_clr_i      (clr),
    .dis_o          (dis_o),
    .fault_gate_o   (gate_o),
    .fault_pad_oe_o (oe_o),
    .ext_dis_o      (ext_o),
    .low_lat_o      (lat_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Advance n rising edges, ending on a falling edge.
  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    dis_pin = 0; sw_dis = 0; ext_drv = 0;
    flag = '0; en = '0; alm = '0; clr = '0;
    rst_n = 0;
    step(2);
    rst_n = 1;
    step(3);
  endtask

  // Set the fault latch with a one-cycle power-high pulse.
  task automatic raise_fault();
    en = 4'b0001; flag = 4'b0001;
    step(1);
    flag = '0;
  endtask

  initial begin
    do_reset();
    // R10: idle state after reset
    chk("R10 gate", 32'(gate_o), 0);
    chk("R10 dis",  32'(dis_o), 0);
    chk("R10 ext",  32'(ext_o), 0);
    chk("R10 lat",  32'(lat_o), 0);
    chk("R10 oe",   32'(oe_o), 0);

    // R2 sweep with settling window closed
    for (int v = 0; v < 256; v++) begin
      do_reset();
      flag = v[3:0]; en = v[7:4];
      step(1);
      chk("R2 gate", 32'(gate_o), 32'(|(v[3:0] & v[7:4])));
      chk("R6 oe",   32'(oe_o),   32'(|(v[3:0] & v[7:4])));
      chk("R1 dis",  32'(dis_o),  32'(|(v[3:0] & v[7:4])));
    end

    // R5 sweep with settling window open: power-low term masked
    for (int v = 0; v < 256; v++) begin
      do_reset();
      sw_dis = 1;
      step(1);
      flag = v[3:0]; en = v[7:4];
      step(1);
      chk("R5 gate", 32'(gate_o), 32'(|(v[3:0] & v[7:4] & 4'b0111)));
      chk("R1 sw",   32'(dis_o), 1);
    end

    // R1 pin path: two edges of synchronizer latency
    do_reset();
    dis_pin = 1;
    step(1);
    chk("R1 pin early", 32'(dis_o), 0);
    step(1);
    chk("R1 pin", 32'(dis_o), 1);
    dis_pin = 0;

    // R3 stretch length
    do_reset();
    sw_dis = 1;
    step(2);
    sw_dis = 0;
    chk("R3 k0", 32'(ext_o), 1);
    for (int k = 1; k < SET_C; k++) begin
      step(1);
      chk("R3 hold", 32'(ext_o), 1);
    end
    step(1);
    chk("R3 end", 32'(ext_o), 0);

    // R5 boundary: power-low held through the window, fires right after
    do_reset();
    en = 4'b1000; sw_dis = 1; flag = 4'b1000;
    step(2);
    chk("R5 during", 32'(gate_o), 0);
    sw_dis = 0;
    step(SET_C);
    chk("R5 tail", 32'(gate_o), 0);
    step(1);
    chk("R5 after", 32'(gate_o), 1);

    // R4 plain latch, hold, clear, set-wins-over-clear
    for (int i = 0; i < LOW_N; i++) begin
      do_reset();
      alm = LOW_N'(1) << i;
      step(1);
      alm = '0;
      step(2);
      chk("R4 hold", 32'(lat_o), 32'(LOW_N'(1) << i));
      clr = LOW_N'(1) << i; alm = LOW_N'(1) << i;
      step(1);
      chk("R4 set wins", 32'(lat_o), 32'(LOW_N'(1) << i));
      alm = '0;
      step(1);
      clr = '0;
      chk("R4 clear", 32'(lat_o), 0);
    end

    // R4 inhibit through the window, capture on the first edge after it
    for (int i = 0; i < LOW_N; i++) begin
      do_reset();
      sw_dis = 1;
      alm = LOW_N'(1) << i;
      step(2);
      chk("R4 blocked", 32'(lat_o), 0);
      sw_dis = 0;
      step(SET_C);
      chk("R4 tail", 32'(lat_o), 0);
      step(1);
      chk("R4 open", 32'(lat_o), 32'(LOW_N'(1) << i));
      alm = '0;
    end

    // R8 short request leaves fault set, full request clears
    do_reset();
    raise_fault();
    chk("R6 set", 32'(gate_o), 1);
    sw_dis = 1;
    step(CLR_C - 1);
    sw_dis = 0;
    chk("R8 short", 32'(gate_o), 1);
    step(1);
    chk("R8 short kept", 32'(gate_o), 1);
    sw_dis = 1;
    step(CLR_C - 1);
    chk("R8 one before", 32'(gate_o), 1);
    step(1);
    chk("R8 cleared", 32'(gate_o), 0);
    chk("R6 oe off", 32'(oe_o), 0);
    sw_dis = 0;
    // R7 own echo on the pin must not re-set the latch
    step(4);
    chk("R7 echo", 32'(gate_o), 0);

    // R9 live fault re-sets at clear
    do_reset();
    en = 4'b0001; flag = 4'b0001;
    step(1);
    sw_dis = 1;
    step(CLR_C + 3);
    chk("R9 stays", 32'(gate_o), 1);
    sw_dis = 0;

    // R7 external pin level
    do_reset();
    ext_drv = 1;
    step(2);
    chk("R7 early", 32'(gate_o), 0);
    step(1);
    chk("R7 set", 32'(gate_o), 1);
    ext_drv = 0;
    step(3);
    chk("R7 latched", 32'(gate_o), 1);

    // R10 asynchronous clear of a set latch
    rst_n = 0;
    #1;
    chk("R10 async", 32'(gate_o), 0);
    chk("R10 async oe", 32'(oe_o), 0);
    step(2);
    rst_n = 1;
    step(3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog all-reqs actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule